// File: doc/BRIEF.md
# Lag-Correlation Health Monitor for a Raw Random Bit Stream

This block watches the raw one-bit output of a physical noise source and flags it when the stream shows bias or correlation between bits. It runs on the sampler clock. On each cycle where the source presents a valid bit, the monitor compares that bit with earlier bits, one comparison per configured lag. Lag 1 compares with the bit just before it. The other lags reach further back through a short shift register of history.

Each lag has a signed counter. The counter steps up when the two bits agree and down when they differ. For an ideal source it stays near zero. A stuck or biased source pushes it toward +block length. A source that tends to alternate pushes it toward -block length.

The stream is cut into non-overlapping blocks of a fixed number of evaluated bits. At the end of each block the magnitude of every lag counter is compared with a limit that software loads for that lag. The monitor then emits a one-cycle done pulse, a per-lag fail vector and a sticky alarm, and every counter restarts from zero. The alarm stays set until the system clears it on purpose.

Top module: `ac_health_mon`

## Requirements
- R1: An accepted bit is compared, for each lag k in the lag list (default 1, 2, 3, 8), with the bit accepted exactly k accepted bits earlier. Bits that were not accepted in between do not count.
- R2: After reset, the first MAX_LAG accepted bits only fill the history. They change no counter and do not count toward a block. MAX_LAG is the largest lag in the list.
- R3: For each evaluated bit, every lag counter moves by +1 if the two compared bits are equal and by -1 if they differ. Its magnitude never exceeds BLOCK_LEN.
- R4: When the BLOCK_LEN-th evaluated bit of a block is taken, `lag_fail[i]` becomes 1 exactly when the magnitude of lag i's final count is strictly greater than threshold i. Otherwise it becomes 0. Equality does not fail. `lag_fail` changes only together with `block_done`.
- R5: `block_done` is high for exactly one cycle, the cycle after the edge that took the last bit of a block. The next block's counts start from zero.
- R6: `fail_sticky` goes high with `block_done` when any lag fails. It stays high until a cycle with `fail_clr` high. A new failure in the same cycle as `fail_clr` wins, and the flag stays set.
- R7: A bit is accepted only when `enable` and `bit_valid` are both high at a rising edge. Otherwise it changes neither history, counts nor outputs.
- R8: Threshold i is written when `thr_we` is high and `thr_sel` equals i. The new value applies to blocks that end after the write edge. At reset every threshold is all ones, its maximum.
- R9: While reset is active and right after it, `block_done`, `lag_fail` and `fail_sticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampler clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows bits to be accepted |
| bit_valid | input | 1 | Raw bit on `bit_in` is valid this cycle |
| bit_in | input | 1 | Raw bit from the noise source |
| thr_we | input | 1 | Threshold write strobe |
| thr_sel | input | SELW | Lag index of the threshold being written |
| thr_wdata | input | MW | Threshold magnitude, MW = clog2(BLOCK_LEN)+1 |
| fail_clr | input | 1 | Clears the sticky alarm |
| block_done | output | 1 | One-cycle pulse at the end of each block |
| lag_fail | output | N_LAGS | Per-lag verdict of the last finished block |
| fail_sticky | output | 1 | Latched alarm: some lag failed since the last clear |

## Verification
The bench builds the monitor with the default lag list 1, 2, 3, 8 and BLOCK_LEN reduced to 32. This keeps blocks short, so dozens of block boundaries and several full fill-and-evaluate sequences fit in a short run. A count of exactly +32 or -32 is reachable with constant and alternating input. With a threshold of 32, and then 31, this probes the strictly-greater boundary on both signs. The 8-deep history makes the gap between lag 8 and the short lags visible. Random gaps in `bit_valid` and `enable` check that only accepted bits shift the history.

// File: rtl/ahm_pkg.sv
package ahm_pkg;
  // width of one entry in the packed lag list
  localparam int LAG_W = 8;

  // +1 when the two compared bits agree, -1 when they differ
  function automatic logic signed [1:0] corr_step(input logic cur, input logic old);
    return (cur ^ old) ? -2'sd1 : 2'sd1;
  endfunction
endpackage

// File: rtl/ahm_delay_line.sv
module ahm_delay_line #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             din,
  output logic [DEPTH-1:0] hist
);
  // hist[0] is the most recent accepted bit, hist[DEPTH-1] the oldest
  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hist <= '0;
        else if (shift) hist <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hist <= '0;
        else if (shift) hist <= {hist[DEPTH-2:0], din};
      end
    end
  endgenerate

  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> hist[0] == $past(din));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !shift |=> $stable(hist));
endmodule

// File: rtl/ahm_block_ctrl.sv
module ahm_block_ctrl #(
  parameter int MAX_LAG   = 8,
  parameter int BLOCK_LEN = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic eval,
  output logic last
);
  localparam int FW = $clog2(MAX_LAG + 1);
  localparam int BW = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;

  logic [FW-1:0] fill_cnt;
  logic [BW-1:0] blk_cnt;
  logic          filled;

  assign filled = (fill_cnt == FW'(MAX_LAG));
  assign eval   = accept && filled;
  assign last   = eval && (blk_cnt == BW'(BLOCK_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
    end else if (accept && !filled) begin
      fill_cnt <= fill_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_cnt <= '0;
    end else if (eval) begin
      blk_cnt <= last ? '0 : blk_cnt + 1'b1;
    end
  end

  p_fill_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    filled |=> filled);
  p_no_eval_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt < FW'(MAX_LAG)) |-> !eval);
  p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, blk_cnt} < (BW+1)'(BLOCK_LEN));
endmodule

// File: rtl/ahm_lag_acc.sv
module ahm_lag_acc
  import ahm_pkg::*;
#(
  parameter int BLOCK_LEN = 1024,
  parameter int AW        = 12,
  parameter int MW        = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eval,
  input  logic          last,
  input  logic          cur_bit,
  input  logic          old_bit,
  input  logic          thr_we,
  input  logic [MW-1:0] thr_wdata,
  output logic          hit,
  output logic          fail_q
);
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] acc_nxt;
  logic        [AW-1:0] mag_nxt;
  logic        [MW-1:0] thr;

  // magnitude of a signed count, returned as an unsigned value
  function automatic logic [AW-1:0] mag(input logic signed [AW-1:0] v);
    return v[AW-1] ? AW'(-v) : AW'(v);
  endfunction

  assign acc_nxt = acc + AW'(corr_step(cur_bit, old_bit));
  assign mag_nxt = mag(acc_nxt);
  assign hit     = last && (mag_nxt > AW'(thr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr <= '1;
    else if (thr_we) thr <= thr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      fail_q <= 1'b0;
    end else if (eval) begin
      if (last) begin
        acc    <= '0;
        fail_q <= hit;
      end else begin
        acc    <= acc_nxt;
      end
    end
  end

  p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mag(acc) <= AW'(BLOCK_LEN));
  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !last) |=> (mag(acc - $past(acc)) == AW'(1)));
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> acc == '0);
  p_fail_only_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(fail_q));
endmodule

// File: rtl/ac_health_mon.sv
module ac_health_mon
  import ahm_pkg::*;
#(
  parameter int                      N_LAGS    = 4,
  parameter logic [N_LAGS*LAG_W-1:0] LAGS      = {8'd8, 8'd3, 8'd2, 8'd1},
  parameter int                      BLOCK_LEN = 1024,
  localparam int                     MW        = $clog2(BLOCK_LEN) + 1,
  localparam int                     SELW      = (N_LAGS > 1) ? $clog2(N_LAGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              thr_we,
  input  logic [SELW-1:0]   thr_sel,
  input  logic [MW-1:0]     thr_wdata,
  input  logic              fail_clr,
  output logic              block_done,
  output logic [N_LAGS-1:0] lag_fail,
  output logic              fail_sticky
);
  localparam int AW = MW + 1;

  function automatic int largest_lag();
    int m = 1;
    for (int i = 0; i < N_LAGS; i++) begin
      if (int'(LAGS[i*LAG_W +: LAG_W]) > m) m = int'(LAGS[i*LAG_W +: LAG_W]);
    end
    return m;
  endfunction

  localparam int MAX_LAG = largest_lag();

  logic               accept;
  logic               eval;
  logic               last;
  logic [MAX_LAG-1:0] hist;
  logic [N_LAGS-1:0]  hit;

  assign accept = enable && bit_valid;

  ahm_delay_line #(.DEPTH(MAX_LAG)) i_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (accept),
    .din   (bit_in),
    .hist  (hist)
  );

  ahm_block_ctrl #(.MAX_LAG(MAX_LAG), .BLOCK_LEN(BLOCK_LEN)) i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .eval   (eval),
    .last   (last)
  );

  generate
    for (genvar g = 0; g < N_LAGS; g++) begin : g_lag
      localparam int K = int'(LAGS[g*LAG_W +: LAG_W]);
      ahm_lag_acc #(.BLOCK_LEN(BLOCK_LEN), .AW(AW), .MW(MW)) i_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval      (eval),
        .last      (last),
        .cur_bit   (bit_in),
        .old_bit   (hist[K-1]),
        .thr_we    (thr_we && (thr_sel == SELW'(g))),
        .thr_wdata (thr_wdata),
        .hit       (hit[g]),
        .fail_q    (lag_fail[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      block_done  <= 1'b0;
      fail_sticky <= 1'b0;
    end else begin
      block_done <= last;
      if (|hit)         fail_sticky <= 1'b1;
      else if (fail_clr) fail_sticky <= 1'b0;
    end
  end

  p_verdict_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !block_done |-> $stable(lag_fail));
  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_sticky && !fail_clr) |=> fail_sticky);
  p_sticky_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (block_done && |lag_fail) |-> fail_sticky);
  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !block_done);
  generate
    if (BLOCK_LEN > 1) begin : g_pulse_chk
      p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |=> !block_done);
    end
  endgenerate
endmodule

// File: tb/test_ac_health_mon.sv
module test_ac_health_mon;
  localparam int CLK_PERIOD = 10;
  localparam int NL   = 4;
  localparam int BL   = 32;
  localparam int MAXL = 8;
  localparam int MWT  = $clog2(BL) + 1;
  localparam int WATCHDOG = 20000;

  int lag_tb [NL] = '{1, 2, 3, 8};

  logic clk = 0;
  logic rst_n = 0;
  logic enable = 0, bit_valid = 0, bit_in = 0, thr_we = 0, fail_clr = 0;
  logic [1:0] thr_sel = 0;
  logic [MWT-1:0] thr_wdata = 0;
  logic block_done, fail_sticky;
  logic [NL-1:0] lag_fail;

  ac_health_mon #(.N_LAGS(NL), .LAGS({8'd8, 8'd3, 8'd2, 8'd1}), .BLOCK_LEN(BL)) i_ac_health_mon (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bit_valid(bit_valid), .bit_in(bit_in),
    .thr_we(thr_we), .thr_sel(thr_sel), .thr_wdata(thr_wdata), .fail_clr(fail_clr),
    .block_done(block_done), .lag_fail(lag_fail), .fail_sticky(fail_sticky));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;

  // behavioural reference model
  int hist_q[$];
  int m_acc [NL];
  int m_thr [NL];
  int m_cnt = 0;
  logic m_done = 0, m_sticky = 0;
  logic [NL-1:0] m_fail = '0;

  function automatic int iabs(int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic model_edge(bit en, bit v, bit b, bit we, int sel, int wd, bit clr);
    bit any = 0;
    m_done = 0;
    if (en && v) begin
      if (hist_q.size() >= MAXL) begin  // R2: only after history is full
        for (int i = 0; i < NL; i++)
          m_acc[i] += ((b ^ hist_q[lag_tb[i]-1][0]) != 0) ? -1 : 1;  // R1 R3
        m_cnt++;
        if (m_cnt == BL) begin
          for (int i = 0; i < NL; i++) begin
            m_fail[i] = iabs(m_acc[i]) > m_thr[i];  // R4 strictly greater
            if (m_fail[i]) any = 1;
            m_acc[i] = 0;
          end
          m_cnt = 0;
          m_done = 1;
        end
      end
      hist_q.push_front(int'(b));
      if (hist_q.size() > MAXL) void'(hist_q.pop_back());
    end
    if (we) m_thr[sel] = wd;  // R8: applies after this edge
    if (any) m_sticky = 1;
    else if (clr) m_sticky = 0;
  endtask

  task automatic compare();
    chk("R5 block_done", int'(block_done), int'(m_done));
    chk("R4 lag_fail", int'(lag_fail), int'(m_fail));
    chk("R6 fail_sticky", int'(fail_sticky), int'(m_sticky));
  endtask

  // called at a falling edge; drives, waits one rising edge, checks at the next falling edge
  task automatic step(bit en, bit v, bit b, bit we, int sel, int wd, bit clr);
    enable = en; bit_valid = v; bit_in = b; thr_we = we;
    thr_sel = sel[1:0]; thr_wdata = wd[MWT-1:0]; fail_clr = clr;
    @(posedge clk);
    model_edge(en, v, b, we, sel, wd, clr);
    @(negedge clk);
    compare();
  endtask

  task automatic set_thr(int sel, int wd);
    step(0, 1, 1, 1, sel, wd, 0);  // R7: bit with enable low is ignored
  endtask

  task automatic feed(int n, int mode);
    for (int i = 0; i < n; i++) begin
      bit b = (mode == 0) ? 1'b0 : (mode == 1) ? i[0] : 1'($urandom_range(0, 1));
      step(1, 1, b, 0, 0, 0, 0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_acc[i] = 0; m_thr[i] = (1 << MWT) - 1; end
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 block_done in reset", int'(block_done), 0);
    chk("R9 lag_fail in reset", int'(lag_fail), 0);
    chk("R9 fail_sticky in reset", int'(fail_sticky), 0);
    rst_n = 1;
    @(negedge clk);
    compare();

    // R8: load thresholds equal to the block length (boundary)
    for (int i = 0; i < NL; i++) set_thr(i, BL);
    // R2: fill plus one full block of zeros; counts reach +32, equal to limit: no fail
    feed(MAXL + BL, 0);
    chk("R4 equality does not fail", int'(lag_fail), 0);
    // R8: tighten lag 0 only; R4: magnitude 32 > 31 fails lag 0
    set_thr(0, BL - 1);
    feed(BL, 0);
    chk("R4 only lag1 fails", int'(lag_fail), 1);
    chk("R6 sticky set", int'(fail_sticky), 1);
    // R7: invalid bits change nothing, sticky holds without clear
    for (int i = 0; i < 20; i++) step(1, 0, 1'(i), 0, 0, 0, 0);
    chk("R6 sticky holds", int'(fail_sticky), 1);
    step(0, 0, 0, 0, 0, 0, 1);
    chk("R6 sticky cleared", int'(fail_sticky), 0);
    // alternating pattern: negative counts on odd lags
    for (int i = 0; i < NL; i++) set_thr(i, BL - 1);
    feed(3 * BL, 1);
    // random stream with gaps, enable drops and random clears
    for (int i = 0; i < NL; i++) set_thr(i, 12 + i);
    for (int i = 0; i < 40 * BL; i++) begin
      step(($urandom_range(0, 9) != 0), ($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 199) == 0), $urandom_range(0, NL - 1), $urandom_range(8, 24),
           ($urandom_range(0, 15) == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule